// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives a slower clock from an input clock. The division factor is set at run time as two separate counts. One count gives the number of input cycles the output stays high and the other gives the number it stays low, so the output period is their sum. A half-step flag shifts the falling edge half an input cycle earlier. With that flag set, an odd division factor gives a 50% duty cycle: put the larger half of the split in the high count.

New settings are taken from the inputs on a rising input edge where the load strobe is high. They are held in a pending stage and copied into the running counter only at the boundary of an output period. The divider therefore never makes a shortened or stretched pulse when it is reprogrammed, whether for a new frequency (3 to 6 halves the output frequency) or a new duty cycle (50%, then 25%, then 75%). A zero count is raised to one. The half-step is dropped when the high phase is only one cycle long, so the output always has a high phase.

Top module: `cdiv_top`

## Requirements
- R1: While reset is asserted the output is low. On the first rising input edge after reset is released, the output goes high and the first high phase begins.
- R2: With the half-step off, the output is high for exactly the effective high count and low for exactly the effective low count, both in input cycles. The period is the sum of the two.
- R3: With the half-step on, the high phase lasts the effective high count minus half an input cycle and the low phase the effective low count plus half a cycle. The total period is unchanged.
- R4: A programmed high or low count of 0 behaves exactly like a count of 1.
- R5: The half-step flag has no effect when the effective high count is 1.
- R6: Count and flag inputs are captured only on a rising input edge where load is 1. Changes made while load is 0 leave the output waveform unchanged.
- R7: A newly loaded setting takes effect only at the start of the next output period. The period in progress completes with its old high and low lengths.
- R8: Until the first load after reset, the divider runs with the default settings given by parameters. The defaults are high 2, low 1, half-step on, which gives 1.5 input cycles high and 1.5 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to divide |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cnt | input | CW | High time in input cycles (0 acts as 1) |
| lo_cnt | input | CW | Low time in input cycles (0 acts as 1) |
| odd_mode | input | 1 | 1: move half an input cycle from the high phase to the low phase |
| load | input | 1 | Capture hi_cnt, lo_cnt and odd_mode at this rising edge |
| clk_div | output | 1 | Divided clock |

## Verification
The output is watched at every half input cycle, and the length of each high and low run is recorded. This resolves the half-step shift exactly. A vector table walks through even splits and uneven splits (25% and 75%), divisors 3 and 6, and odd divisors with the half-step on. This separates correct edge placement from an off-by-one or a missing half-cycle. Zero counts, and a half-step requested with a high count of one, separate the floor-to-one rule from pass-through behaviour. A load issued in the middle of a long high phase shows whether the period in progress keeps its old lengths. Input changes without a load, and the defaults measured after reset, cover the capture rule and the reset state.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
   localparam int CDIV_MAX_W = 16;

   typedef enum logic {
      CDIV_FULL = 1'b0,
      CDIV_HALF = 1'b1
   } cdiv_mode_e;
endpackage

// File: rtl/cdiv_cfg.sv
module cdiv_cfg
   import cdiv_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DEF_HI  = 2,
   parameter int DEF_LO  = 1,
   parameter bit DEF_ODD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] hi_in,
   input  logic [CW-1:0] lo_in,
   input  logic          odd_in,
   input  logic          pstart,
   output logic [CW-1:0] act_h,
   output logic [CW-1:0] act_l,
   output cdiv_mode_e    act_mode,
   output logic [CW-1:0] nxt_h,
   output logic [CW-1:0] nxt_l,
   output cdiv_mode_e    nxt_mode
);
   localparam logic [CW-1:0] ONE   = CW'(1);
   localparam logic [CW-1:0] RST_H = (DEF_HI == 0) ? ONE : CW'(DEF_HI);
   localparam logic [CW-1:0] RST_L = (DEF_LO == 0) ? ONE : CW'(DEF_LO);
   localparam cdiv_mode_e    RST_M = (DEF_ODD && RST_H > ONE) ? CDIV_HALF : CDIV_FULL;

   logic [CW-1:0] pend_h, pend_l, hi_c, lo_c;
   cdiv_mode_e    pend_mode;

   assign hi_c = (hi_in == '0) ? ONE : hi_in;
   assign lo_c = (lo_in == '0) ? ONE : lo_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_h    <= RST_H;
         pend_l    <= RST_L;
         pend_mode <= RST_M;
      end else if (load) begin
         pend_h    <= hi_c;
         pend_l    <= lo_c;
         pend_mode <= (odd_in && hi_c > ONE) ? CDIV_HALF : CDIV_FULL;
      end
   end

   assign nxt_h    = pstart ? pend_h    : act_h;
   assign nxt_l    = pstart ? pend_l    : act_l;
   assign nxt_mode = pstart ? pend_mode : act_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_h    <= RST_H;
         act_l    <= RST_L;
         act_mode <= RST_M;
      end else begin
         act_h    <= nxt_h;
         act_l    <= nxt_l;
         act_mode <= nxt_mode;
      end
   end

   // R7: the running setting only moves at a period boundary
   a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
      !pstart |=> ($stable(act_h) && $stable(act_l) && $stable(act_mode)));

   // R4: the running counts are never zero
   a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (act_h != '0) && (act_l != '0));
endmodule

// File: rtl/cdiv_count.sv
module cdiv_count
   import cdiv_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] act_h,
   input  logic [CW-1:0] act_l,
   input  cdiv_mode_e    act_mode,
   input  logic [CW-1:0] nxt_h,
   input  cdiv_mode_e    nxt_mode,
   output logic          pstart,
   output logic          gate
);
   localparam int PW = CW + 1;

   logic          started;
   logic [PW-1:0] pos, npos, total;
   logic [CW-1:0] heff;
   logic          wrap;

   assign total  = PW'(act_h) + PW'(act_l);
   assign wrap   = started && (pos == total - PW'(1));
   assign pstart = !started || wrap;
   assign npos   = pstart ? '0 : pos + PW'(1);
   assign heff   = (nxt_mode == CDIV_HALF) ? nxt_h - CW'(1) : nxt_h;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started <= 1'b0;
         pos     <= '0;
         gate    <= 1'b0;
      end else begin
         started <= 1'b1;
         pos     <= npos;
         gate    <= (npos < PW'(heff));
      end
   end

   // R2: position stays inside the period
   a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (pos < total));

   // R1: every high phase begins at position zero
   a_r1_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> (pos == '0));

   // R1: the first edge after reset opens a high phase
   a_r1_first_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started) |-> gate);

   // R2: the gate drops exactly when the high length is used up
   a_r2_fall_point: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate) |-> (pos == PW'((act_mode == CDIV_HALF) ? act_h - CW'(1) : act_h)));
endmodule

// File: rtl/cdiv_halfstep.sv
module cdiv_halfstep
   import cdiv_pkg::*;
#(
   parameter bit HALF_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       gate,
   input  cdiv_mode_e mode,
   output logic       clk_out
);
   generate
      if (HALF_EN) begin : g_half
         logic trail;

         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) trail <= 1'b0;
            else        trail <= gate;
         end

         assign clk_out = gate | ((mode == CDIV_HALF) & trail);

         // R3: in half-step mode the output outlives the gate until the next falling edge
         a_r3_half_tail: assert property (@(negedge clk) disable iff (!rst_n)
            ((mode == CDIV_HALF) && !gate && $past(gate)) |-> clk_out);
      end else begin : g_full
         logic unused_mode;
         assign unused_mode = mode[0];
         assign clk_out = gate;
      end
   endgenerate
endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
   import cdiv_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DEF_HI  = 2,
   parameter int DEF_LO  = 1,
   parameter bit DEF_ODD = 1'b1,
   parameter bit HALF_EN = 1'b1
) (
   input  logic          clk_in,
   input  logic          rst_n,
   input  logic [CW-1:0] hi_cnt,
   input  logic [CW-1:0] lo_cnt,
   input  logic          odd_mode,
   input  logic          load,
   output logic          clk_div
);
   generate
      if (CW < 2 || CW > CDIV_MAX_W) begin : g_bad_cw
         $error("cdiv_top: CW out of range");
      end
      if (DEF_HI < 0 || DEF_HI >= (1 << CW) || DEF_LO < 0 || DEF_LO >= (1 << CW)) begin : g_bad_def
         $error("cdiv_top: default counts do not fit CW");
      end
      if (DEF_ODD && !HALF_EN) begin : g_bad_odd
         $error("cdiv_top: half-step default needs HALF_EN");
      end
   endgenerate

   logic [CW-1:0] act_h, act_l, nxt_h, nxt_l;
   cdiv_mode_e    act_mode, nxt_mode;
   logic          pstart, gate, odd_q;

   assign odd_q = HALF_EN ? odd_mode : 1'b0;

   cdiv_cfg #(.CW(CW), .DEF_HI(DEF_HI), .DEF_LO(DEF_LO), .DEF_ODD(DEF_ODD)) u_cfg (
      .clk(clk_in), .rst_n(rst_n), .load(load),
      .hi_in(hi_cnt), .lo_in(lo_cnt), .odd_in(odd_q), .pstart(pstart),
      .act_h(act_h), .act_l(act_l), .act_mode(act_mode),
      .nxt_h(nxt_h), .nxt_l(nxt_l), .nxt_mode(nxt_mode)
   );

   cdiv_count #(.CW(CW)) u_cnt (
      .clk(clk_in), .rst_n(rst_n),
      .act_h(act_h), .act_l(act_l), .act_mode(act_mode),
      .nxt_h(nxt_h), .nxt_mode(nxt_mode),
      .pstart(pstart), .gate(gate)
   );

   cdiv_halfstep #(.HALF_EN(HALF_EN)) u_half (
      .clk(clk_in), .rst_n(rst_n), .gate(gate), .mode(act_mode), .clk_out(clk_div)
   );

   logic unused_nxt_l;
   assign unused_nxt_l = ^nxt_l;

   // R1: output is low during reset (checked on the first sampled edge after release)
   a_r1_low_in_reset: assert property (@(posedge clk_in) $rose(rst_n) |-> !$past(clk_div));
endmodule

// File: tb/sim_cdiv_top.sv
module sim_cdiv_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] hi_cnt = '0, lo_cnt = '0;
   logic       odd_mode = 1'b0, load = 1'b0;
   logic       clk_div;

   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   cdiv_top u0 (.clk_in(clk), .rst_n(rst_n), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
                .odd_mode(odd_mode), .load(load), .clk_div(clk_div));

   // run-length monitor in half input cycles
   int hist_h [0:511];
   int hist_l [0:511];
   int pcount = 0;
   initial begin
      logic s, s_prev;
      int run, last_h;
      bit have_h;
      s_prev = 1'b0; run = 0; last_h = 0; have_h = 0;
      forever begin
         @(clk);
         #2;
         if (!rst_n) begin
            s_prev = 1'b0; run = 0; have_h = 0;
         end else begin
            s = clk_div;
            if (s == s_prev) run++;
            else begin
               if (s_prev) begin last_h = run; have_h = 1; end
               else if (have_h && pcount < 512) begin
                  hist_h[pcount] = last_h;
                  hist_l[pcount] = run;
                  pcount++;
               end
               run = 1;
            end
            s_prev = s;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_load(input int h, input int l, input bit o);
      @(negedge clk);
      hi_cnt = 8'(h); lo_cnt = 8'(l); odd_mode = o; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   typedef struct packed {
      logic [7:0] h;
      logic [7:0] l;
      logic       o;
      int         eh;
      int         el;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{8'd1, 8'd2, 1'b0,  2,  4},   // R2 divide by 3
      '{8'd3, 8'd3, 1'b0,  6,  6},   // R2 divide by 6, half frequency
      '{8'd2, 8'd1, 1'b1,  3,  3},   // R3 odd 3 at 50%
      '{8'd4, 8'd4, 1'b0,  8,  8},   // R2 50%
      '{8'd2, 8'd6, 1'b0,  4, 12},   // R2 25%
      '{8'd6, 8'd2, 1'b0, 12,  4},   // R2 75%
      '{8'd3, 8'd2, 1'b1,  5,  5},   // R3 odd 5
      '{8'd0, 8'd0, 1'b0,  2,  2},   // R4 both zero
      '{8'd0, 8'd3, 1'b1,  2,  6},   // R4 R5 zero high, half-step dropped
      '{8'd1, 8'd2, 1'b1,  2,  4},   // R5 high one, half-step dropped
      '{8'd5, 8'd0, 1'b0, 10,  2},   // R4 zero low
      '{8'd7, 8'd6, 1'b1, 13, 13}    // R3 odd 13
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int k;
      repeat (4) @(posedge clk);
      #1 chk("R1 low in reset", clk_div, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      #1 chk("R1 low before first edge", clk_div, 0);
      @(posedge clk); #1 chk("R1 high after first edge", clk_div, 1);

      // R8 defaults: 2/1 with half-step gives 3/3 halves
      wait (pcount >= 2);
      chk("R8 default high", hist_h[1], 3);
      chk("R8 default low",  hist_l[1], 3);

      for (int i = 0; i < NV; i++) begin
         do_load(int'(VEC[i].h), int'(VEC[i].l), VEC[i].o);
         k = pcount;
         wait (pcount >= k + 3);
         chk($sformatf("R2/R3 vec %0d high", i), hist_h[k+2], VEC[i].eh);
         chk($sformatf("R2/R3 vec %0d low",  i), hist_l[k+2], VEC[i].el);
      end

      // R7: load in the middle of a long high phase
      do_load(4, 4, 1'b0);
      k = pcount; wait (pcount >= k + 2);
      @(posedge clk_div); #3;
      k = pcount;
      do_load(1, 1, 1'b0);
      wait (pcount >= k + 2);
      chk("R7 old period high", hist_h[k], 8);
      chk("R7 old period low",  hist_l[k], 8);
      chk("R7 new period high", hist_h[k+1], 2);
      chk("R7 new period low",  hist_l[k+1], 2);

      // R6: inputs move without load, output unchanged
      @(negedge clk);
      hi_cnt = 8'd5; lo_cnt = 8'd7; odd_mode = 1'b1;
      k = pcount;
      wait (pcount >= k + 3);
      chk("R6 no-load high", hist_h[k+2], 2);
      chk("R6 no-load low",  hist_l[k+2], 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule